// File: doc/BRIEF.md
# Event Routing Crossbar

This block passes one-cycle event pulses from peripherals that produce them (timer overflows, comparator toggles, conversion-done strobes, transfer-done strobes) to peripherals that act on them (conversion start, transfer request, timer output control). No processor is involved. A set of channels runs side by side. Each channel picks one generator. Each user picks one channel or none. Software writes these selections through a small register port and can read them back.

The path from a generator to a user always has two register stages: a generator-select stage per channel and a channel-select stage per user. The delay is therefore the same for every routing and does not depend on what else is happening on the chip. Chains are built outside the block. A user output drives a peripheral, and that peripheral's completion strobe comes back in as another generator. Each hop adds the same fixed delay.

Top module: `evroute`

## Requirements
- R1: After reset every user output is low, every channel selects generator 0, and every user holds code 0 (listens to nothing).
- R2: A generator pulse sampled at clock edge k shows up on each user routed to it during the cycle after edge k+1, and for that one cycle only. The latency is two cycles for every routing.
- R3: Writing address c, for c below the channel count, stores the low generator-index bits of the write data as channel c's generator selection. Reading address c returns that value, zero-extended.
- R4: Writing address N_CH+u stores the low code bits as user u's selection. Code k, for k from 1 to N_CH, makes the user follow channel k-1. Reading the address returns the stored code, zero-extended.
- R5: A user holding code 0 never raises its output, whatever the generators do.
- R6: All channels carry events in the same cycle, independently of each other. Every user that follows the same channel receives that channel's pulse.
- R7: A generator that pulses on two consecutive cycles gives two consecutive output cycles on its users. No pulse is lost or merged.
- R8: After a channel-selection write sampled at edge t, pulses sampled at edge t still travel on the old generator, and pulses from edge t+1 onward use the new one. A user output is never raised unless a generator pulsed two edges earlier.
- R9: A stored user code above N_CH acts like code 0. Writes to addresses at or above N_CH+N_USR change nothing, and reads of those addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_i | input | N_GEN | One-cycle event pulses from generators |
| usr_o | output | N_USR | One-cycle event pulses to users |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | clog2(N_CH+N_USR) | Register address, used for both write and read |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Combinational read data for cfg_addr |

## Verification
An event result is due exactly two rising edges after the edge that samples the generator pulse. The bench drives stimulus on falling edges and checks the output at the falling edge after one rising edge, where it must still be low, and again after two rising edges, where the pulse must be present. A selection write counts from the edge that samples it. The reconfiguration test therefore fires the old and the new generator in the write cycle and in the cycles after it, and checks each expected result at its own falling edge. Read data is combinational, so readback is checked one time step after the address is set.

// File: rtl/evroute.sv
module evroute #(
  parameter int N_GEN  = 16,
  parameter int N_CH   = 8,
  parameter int N_USR  = 16,
  parameter int DATA_W = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [N_GEN-1:0]                     gen_i,
  output logic [N_USR-1:0]                     usr_o,
  input  logic                                 cfg_we,
  input  logic [$clog2(N_CH+N_USR)-1:0]        cfg_addr,
  input  logic [DATA_W-1:0]                    cfg_wdata,
  output logic [DATA_W-1:0]                    cfg_rdata
);
  localparam int GW    = $clog2(N_GEN);
  localparam int UW    = $clog2(N_CH + 1);
  localparam int CW    = $clog2(N_CH);
  localparam int N_REG = N_CH + N_USR;
  localparam int AW    = $clog2(N_REG);

  logic [GW-1:0]    ch_sel  [N_CH];
  logic [UW-1:0]    usr_sel [N_USR];
  logic [N_CH-1:0]  ch_q;
  logic [N_USR-1:0] usr_q;

  assign usr_o = usr_q;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)
        ch_sel[c] <= '0;
      else if (cfg_we && cfg_addr == AW'(c))
        ch_sel[c] <= cfg_wdata[GW-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) ch_q[c] <= 1'b0;
      else        ch_q[c] <= gen_i[ch_sel[c]];
    end
  end

  for (genvar u = 0; u < N_USR; u++) begin : g_usr
    logic          live;
    logic [CW-1:0] idx;

    assign live = (usr_sel[u] != '0) && (usr_sel[u] <= UW'(N_CH));
    assign idx  = CW'(usr_sel[u] - UW'(1));

    always_ff @(posedge clk) begin
      if (!rst_n)
        usr_sel[u] <= '0;
      else if (cfg_we && cfg_addr == AW'(N_CH + u))
        usr_sel[u] <= cfg_wdata[UW-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) usr_q[u] <= 1'b0;
      else        usr_q[u] <= live & ch_q[idx];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int c = 0; c < N_CH; c++)
      if (cfg_addr == AW'(c)) cfg_rdata = DATA_W'(ch_sel[c]);
    for (int u = 0; u < N_USR; u++)
      if (cfg_addr == AW'(N_CH + u)) cfg_rdata = DATA_W'(usr_sel[u]);
  end
endmodule

module evroute_chk #(
  parameter int N_GEN  = 16,
  parameter int N_CH   = 8,
  parameter int N_USR  = 16,
  parameter int DATA_W = 8,
  localparam int GW    = $clog2(N_GEN),
  localparam int UW    = $clog2(N_CH + 1),
  localparam int N_REG = N_CH + N_USR,
  localparam int AW    = $clog2(N_REG)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_GEN-1:0]  gen_i,
  input logic [N_USR-1:0]  usr_o,
  input logic              cfg_we,
  input logic [AW-1:0]     cfg_addr,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic [GW-1:0]     ch_sel  [N_CH],
  input logic [UW-1:0]     usr_sel [N_USR]
);
  logic [1:0]       age;
  logic [N_USR-1:0] hit;

  always_ff @(posedge clk) begin
    if (!rst_n)        age <= 2'd0;
    else if (age != 2) age <= age + 2'd1;
  end

  for (genvar u = 0; u < N_USR; u++) begin : g_u
    always_comb begin
      hit[u] = 1'b0;
      for (int c = 0; c < N_CH; c++)
        if (usr_sel[u] == UW'(c + 1)) hit[u] = gen_i[ch_sel[c]];
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2 && !$past(cfg_we, 2)) |-> usr_o[u] == $past(hit[u], 2));

    p_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (usr_sel[u] == '0 || usr_sel[u] > UW'(N_CH)) |=> !usr_o[u]);

    p_wr_usr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == AW'(N_CH + u)) |=> usr_sel[u] == $past(cfg_wdata[UW-1:0]));
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_c
    p_wr_ch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == AW'(c)) |=> ch_sel[c] == $past(cfg_wdata[GW-1:0]));

    p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && 32'(cfg_addr) >= N_REG) |=> $stable(ch_sel[c]));
  end

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2) |-> usr_o == '0);

  p_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (usr_o != '0) |-> $past(gen_i, 2) != '0);
endmodule

bind evroute evroute_chk #(.N_GEN(N_GEN), .N_CH(N_CH), .N_USR(N_USR), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gen_i(gen_i), .usr_o(usr_o), .cfg_we(cfg_we),
  .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .ch_sel(ch_sel), .usr_sel(usr_sel));

// File: tb/tb_evroute.sv
module tb_evroute;
  localparam int N_GEN = 16, N_CH = 8, N_USR = 16, DATA_W = 8;
  localparam int AW = $clog2(N_CH + N_USR);

  logic clk = 1'b0;
  logic rst_n;
  logic [N_GEN-1:0] gen_i;
  logic [N_USR-1:0] usr_o;
  logic cfg_we;
  logic [AW-1:0] cfg_addr;
  logic [DATA_W-1:0] cfg_wdata, cfg_rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [7:0] shadow [N_CH + N_USR];

  // {generator pattern, expected user outputs}
  localparam logic [31:0] VEC [8] = '{
    {16'h0004, 16'h8101}, {16'h0020, 16'h0002}, {16'h0100, 16'h0204},
    {16'h4000, 16'h0410}, {16'h0090, 16'h48C0}, {16'hFFFF, 16'hCFFF},
    {16'h0802, 16'h0028}, {16'hB649, 16'h0000}};

  always #2 clk = ~clk;

  evroute #(.N_GEN(N_GEN), .N_CH(N_CH), .N_USR(N_USR), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .gen_i(gen_i), .usr_o(usr_o), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [7:0] d);
    cfg_addr = AW'(a);
    #1 d = cfg_rdata;
  endtask

  task automatic fire(logic [15:0] p, logic [15:0] exp, string req);
    @(negedge clk) gen_i = p;
    @(negedge clk) gen_i = '0;
    chk({req, " not early"}, usr_o, 0);
    @(negedge clk) chk(req, usr_o, exp);
    @(negedge clk) chk({req, " one cycle"}, usr_o, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic ok;
    rst_n = 1'b0; gen_i = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 outputs", usr_o, 0);
    rst_n = 1'b1;
    rd(0, d);      chk("R1 ch0 sel", d, 0);
    rd(N_CH, d);   chk("R1 usr0 code", d, 0);
    fire(16'hFFFF, 16'h0000, "R5 default none");

    for (int c = 0; c < N_CH; c++) begin
      shadow[c] = 8'((3 * c + 2) % 16);
      wr(c, shadow[c]);
    end
    for (int u = 0; u < N_USR; u++) begin
      case (u)
        8: shadow[N_CH+u] = 8'd1;   9: shadow[N_CH+u] = 8'd3;
        10: shadow[N_CH+u] = 8'd5;  11: shadow[N_CH+u] = 8'd7;
        12: shadow[N_CH+u] = 8'd0;  13: shadow[N_CH+u] = 8'd12;
        14: shadow[N_CH+u] = 8'd8;  15: shadow[N_CH+u] = 8'd1;
        default: shadow[N_CH+u] = 8'(u + 1);
      endcase
      wr(N_CH + u, shadow[N_CH+u]);
    end
    for (int a = 0; a < N_CH + N_USR; a++) begin
      rd(a, d);
      chk(a < N_CH ? "R3 readback" : "R4 readback", d, shadow[a]);
    end

    wr(24, 8'h0F);
    wr(31, 8'h03);
    rd(24, d); chk("R9 unmapped read", d, 0);
    ok = 1'b1;
    for (int a = 0; a < N_CH + N_USR; a++) begin
      rd(a, d);
      if (d !== shadow[a]) ok = 1'b0;
    end
    chk("R9 unmapped write ignored", ok, 1);

    for (int i = 0; i < 8; i++)
      fire(VEC[i][31:16], VEC[i][15:0], "R2 R6 routing");

    // R7 back-to-back
    @(negedge clk) gen_i = 16'h0004;
    @(negedge clk) gen_i = 16'h0004;
    @(negedge clk) gen_i = '0;
    chk("R7 first", usr_o, 16'h8101);
    @(negedge clk) chk("R7 second", usr_o, 16'h8101);
    @(negedge clk) chk("R7 end", usr_o, 0);

    // R8 channel 1 moves from generator 5 to generator 9
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(1); cfg_wdata = 8'd9; gen_i = 16'h0020;
    @(negedge clk);
    cfg_we = 1'b0; gen_i = 16'h0020;
    @(negedge clk);
    gen_i = 16'h0200;
    chk("R8 old path in write cycle", usr_o, 16'h0002);
    @(negedge clk);
    gen_i = '0;
    chk("R8 old generator dropped", usr_o, 0);
    @(negedge clk) chk("R8 new path", usr_o, 16'h0002);
    @(negedge clk) chk("R8 quiet", usr_o, 0);

    wr(N_CH + 0, 8'd0);
    fire(16'h0004, 16'h8100, "R5 user set to none");
    wr(N_CH + 5, 8'd15);
    fire(16'h0002, 16'h0000, "R9 code above range");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule